// File: doc/BRIEF.md
# Supervisor trap return unit

This block keeps the state a core needs to leave a supervisor trap handler: the current privilege level, the supervisor interrupt-enable bit, its saved copy, the saved previous privilege, and the supervisor exception PC. Each cycle it can take one instruction word with a valid strobe. When that word is the supervisor return instruction, the block checks the current privilege and the trap-return control input. A permitted return redirects the PC to the saved exception PC and restores the status bits, all in one cycle. A forbidden return raises an illegal-instruction exception and leaves the state as it was.

A trap-entry strobe with a PC loads the same state the way a trap into supervisor mode would. A test can therefore enter a trap and return from it. The redirect and exception outputs are registered, one-cycle pulses that appear on the clock edge after the input is presented. The privilege level is encoded as 00 for user, 01 for supervisor and 11 for machine.

Top module: `sret_unit`

## Requirements
- R1: After an asynchronous reset the privilege is 11 (machine), SIE is 1, SPIE is 0, SPP is 0, the exception PC is 0, and neither pulse output is asserted.
- R2: An instruction word is the return only when bits 6..0 are 1110011, bits 14..12 are 000 and bits 31..20 are 0x102. Any other word has no effect on the state and produces no pulse.
- R3: A legal return asserts redirect for one cycle, with the target equal to the saved exception PC, on the edge after the instruction is presented.
- R4: A legal return sets the privilege from SPP: 0 gives user (00), 1 gives supervisor (01).
- R5: A legal return copies SPIE into SIE, sets SPIE to 1 and clears SPP, all on the same edge.
- R6: A return in user mode raises an exception with cause 2 and the instruction word as trap value, and it changes no state.
- R7: A return in supervisor mode with the trap-return control input at 1 raises the same illegal-instruction exception and changes no state.
- R8: A return in machine mode is legal whatever the value of the trap-return control input.
- R9: A trap-entry strobe stores the supplied PC with bit 0 cleared into the exception PC, copies SIE into SPIE, clears SIE, sets SPP to 1 if the prior privilege was not user (0 otherwise), and enters supervisor mode.
- R10: When a trap-entry strobe and an instruction arrive in the same cycle, the trap entry wins and neither pulse output is raised.
- R11: Redirect and exception are never asserted together, and each pulse follows an instruction presented in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Decoded instruction word |
| tsr_i | input | 1 | Trap-return control: 1 forbids the return in supervisor mode |
| trap_valid_i | input | 1 | Trap-entry strobe |
| trap_pc_i | input | XLEN | PC to save on trap entry |
| redirect_valid_o | output | 1 | PC redirect pulse |
| redirect_pc_o | output | XLEN | Redirect target |
| exc_valid_o | output | 1 | Exception pulse |
| exc_cause_o | output | 4 | Exception cause code |
| exc_tval_o | output | 32 | Faulting instruction word |
| priv_o | output | 2 | Current privilege level |
| sie_o | output | 1 | Supervisor interrupt enable |
| spie_o | output | 1 | Saved supervisor interrupt enable |
| spp_o | output | 1 | Saved previous privilege (0 user, 1 supervisor) |
| sepc_o | output | XLEN | Supervisor exception PC |

## Verification
The assertions assume the inputs are known, 0 or 1, on every clock edge after reset. They also assume that the privilege output only ever holds one of the three legal codes, and the block itself keeps that true because it never writes the reserved code 10. The bench changes inputs only at falling edges and holds every strobe low during reset. The only way it reaches a given privilege level is through reset, trap entry or a return, so every state the bench sees is one the block itself produced.

// File: rtl/sret_pkg.sv
package sret_pkg;
  localparam int unsigned ILEN    = 32;
  localparam int unsigned CAUSE_W = 4;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  // opcode 1110011, funct3 000, funct12 0x102; rs1/rd don't care
  localparam logic [ILEN-1:0] RET_MASK  = 32'hFFF0_707F;
  localparam logic [ILEN-1:0] RET_MATCH = 32'h1020_0073;

  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = CAUSE_W'(2);
endpackage

// File: rtl/sret_decode.sv
module sret_decode
  import sret_pkg::*;
(
  input  logic            valid_i,
  input  logic [ILEN-1:0] instr_i,
  output logic            is_ret_o
);
  assign is_ret_o = valid_i && ((instr_i & RET_MASK) == RET_MATCH);
endmodule

// File: rtl/sret_priv_check.sv
module sret_priv_check
  import sret_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       tsr_i,
  output logic       legal_o
);
  always_comb begin
    unique case (priv_i)
      PRIV_M:  legal_o = 1'b1;
      PRIV_S:  legal_o = !tsr_i;
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sret_state.sv
module sret_state
  import sret_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter logic        SIE_RESET = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trap_i,
  input  logic [XLEN-1:0] trap_pc_i,
  input  logic            ret_i,
  output logic [1:0]      priv_o,
  output logic            sie_o,
  output logic            spie_o,
  output logic            spp_o,
  output logic [XLEN-1:0] sepc_o
);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(1);

  logic [1:0]      priv_q, priv_d;
  logic            sie_q, sie_d, spie_q, spie_d, spp_q, spp_d;
  logic [XLEN-1:0] sepc_q, sepc_d;

  always_comb begin
    priv_d = priv_q;
    sie_d  = sie_q;
    spie_d = spie_q;
    spp_d  = spp_q;
    sepc_d = sepc_q;
    if (trap_i) begin
      sepc_d = trap_pc_i & ALIGN_MASK;
      spie_d = sie_q;
      sie_d  = 1'b0;
      spp_d  = (priv_q != PRIV_U);
      priv_d = PRIV_S;
    end else if (ret_i) begin
      priv_d = spp_q ? PRIV_S : PRIV_U;
      sie_d  = spie_q;
      spie_d = 1'b1;
      spp_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q <= PRIV_M;
      sie_q  <= SIE_RESET;
      spie_q <= 1'b0;
      spp_q  <= 1'b0;
      sepc_q <= '0;
    end else begin
      priv_q <= priv_d;
      sie_q  <= sie_d;
      spie_q <= spie_d;
      spp_q  <= spp_d;
      sepc_q <= sepc_d;
    end
  end

  assign priv_o = priv_q;
  assign sie_o  = sie_q;
  assign spie_o = spie_q;
  assign spp_o  = spp_q;
  assign sepc_o = sepc_q;
endmodule

// File: rtl/sret_unit.sv
module sret_unit
  import sret_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter logic        SIE_RESET = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [ILEN-1:0]    instr_i,
  input  logic               tsr_i,
  input  logic               trap_valid_i,
  input  logic [XLEN-1:0]    trap_pc_i,
  output logic               redirect_valid_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic               exc_valid_o,
  output logic [CAUSE_W-1:0] exc_cause_o,
  output logic [ILEN-1:0]    exc_tval_o,
  output logic [1:0]         priv_o,
  output logic               sie_o,
  output logic               spie_o,
  output logic               spp_o,
  output logic [XLEN-1:0]    sepc_o
);
  logic is_ret, legal, do_ret, do_exc;

  sret_decode u_dec (
    .valid_i  (instr_valid_i && !trap_valid_i),
    .instr_i  (instr_i),
    .is_ret_o (is_ret)
  );

  sret_priv_check u_chk_priv (
    .priv_i  (priv_o),
    .tsr_i   (tsr_i),
    .legal_o (legal)
  );

  assign do_ret = is_ret && legal;
  assign do_exc = is_ret && !legal;

  sret_state #(.XLEN(XLEN), .SIE_RESET(SIE_RESET)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trap_i    (trap_valid_i),
    .trap_pc_i (trap_pc_i),
    .ret_i     (do_ret),
    .priv_o    (priv_o),
    .sie_o     (sie_o),
    .spie_o    (spie_o),
    .spp_o     (spp_o),
    .sepc_o    (sepc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_valid_o <= 1'b0;
      redirect_pc_o    <= '0;
      exc_valid_o      <= 1'b0;
      exc_cause_o      <= '0;
      exc_tval_o       <= '0;
    end else begin
      redirect_valid_o <= do_ret;
      exc_valid_o      <= do_exc;
      if (do_ret) redirect_pc_o <= sepc_o;
      if (do_exc) begin
        exc_cause_o <= CAUSE_ILLEGAL;
        exc_tval_o  <= instr_i;
      end
    end
  end
endmodule

// File: rtl/sret_unit_chk.sv
module sret_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            instr_valid_i,
  input logic [31:0]     instr_i,
  input logic            tsr_i,
  input logic            trap_valid_i,
  input logic [XLEN-1:0] trap_pc_i,
  input logic            redirect_valid_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic            exc_valid_o,
  input logic [3:0]      exc_cause_o,
  input logic [1:0]      priv_o,
  input logic            spie_o,
  input logic            spp_o,
  input logic [XLEN-1:0] sepc_o
);
  logic ret_word, issue;
  assign ret_word = instr_i[6:0] == 7'b1110011 && instr_i[14:12] == 3'b000 &&
                    instr_i[31:20] == 12'h102;
  assign issue = instr_valid_i && !trap_valid_i && ret_word;

  assert_pulse_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(redirect_valid_o && exc_valid_o));

  assert_pulse_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |=> (redirect_valid_o || exc_valid_o));

  assert_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> (redirect_pc_o == sepc_o && !redirect_pc_o[0]));

  assert_priv_from_spp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && (priv_o == 2'b11 || (priv_o == 2'b01 && !tsr_i))) |=>
      (priv_o == {1'b0, $past(spp_o)}));

  assert_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> (spie_o && !spp_o));

  assert_user_illegal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && priv_o == 2'b00) |=>
      (exc_valid_o && exc_cause_o == 4'd2 && $stable(priv_o) && $stable(sepc_o)));

  assert_tsr_illegal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && priv_o == 2'b01 && tsr_i) |=> (exc_valid_o && $stable(priv_o)));

  assert_machine_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && priv_o == 2'b11) |=> redirect_valid_o);

  assert_trap_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> (priv_o == 2'b01 && sepc_o == ($past(trap_pc_i) & ~XLEN'(1))));

  assert_trap_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> (!redirect_valid_o && !exc_valid_o));
endmodule

bind sret_unit sret_unit_chk #(.XLEN(XLEN)) u_sret_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .instr_valid_i    (instr_valid_i),
  .instr_i          (instr_i),
  .tsr_i            (tsr_i),
  .trap_valid_i     (trap_valid_i),
  .trap_pc_i        (trap_pc_i),
  .redirect_valid_o (redirect_valid_o),
  .redirect_pc_o    (redirect_pc_o),
  .exc_valid_o      (exc_valid_o),
  .exc_cause_o      (exc_cause_o),
  .priv_o           (priv_o),
  .spie_o           (spie_o),
  .spp_o            (spp_o),
  .sepc_o           (sepc_o)
);

// File: tb/sret_unit_test.sv
module sret_unit_test;
  localparam int XLEN = 32;
  localparam logic [31:0] RET = 32'h1020_0073;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            instr_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic            tsr = 1'b0;
  logic            trap_valid = 1'b0;
  logic [XLEN-1:0] trap_pc = '0;
  logic            redirect_valid, exc_valid, sie, spie, spp;
  logic [XLEN-1:0] redirect_pc, sepc;
  logic [3:0]      exc_cause;
  logic [31:0]     exc_tval;
  logic [1:0]      priv;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sret_unit #(.XLEN(XLEN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid), .instr_i(instr),
    .tsr_i(tsr), .trap_valid_i(trap_valid), .trap_pc_i(trap_pc),
    .redirect_valid_o(redirect_valid), .redirect_pc_o(redirect_pc),
    .exc_valid_o(exc_valid), .exc_cause_o(exc_cause), .exc_tval_o(exc_tval),
    .priv_o(priv), .sie_o(sie), .spie_o(spie), .spp_o(spp), .sepc_o(sepc)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic chk_state(input string req, input logic [1:0] p, input bit e_sie,
                           input bit e_spie, input bit e_spp, input logic [31:0] e_sepc);
    chk_eq({req, " priv"}, 32'(priv), 32'(p));
    chk_eq({req, " sie"}, 32'(sie), 32'(e_sie));
    chk_eq({req, " spie"}, 32'(spie), 32'(e_spie));
    chk_eq({req, " spp"}, 32'(spp), 32'(e_spp));
    chk_eq({req, " sepc"}, sepc, e_sepc);
  endtask

  // drive at falling edge, sample after the next rising edge
  task automatic issue(input logic [31:0] w, input bit t);
    instr_valid = 1'b1; instr = w; tsr = t;
    @(posedge clk); @(negedge clk);
    instr_valid = 1'b0; instr = '0;
  endtask

  task automatic trap(input logic [31:0] pc);
    trap_valid = 1'b1; trap_pc = pc;
    @(posedge clk); @(negedge clk);
    trap_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk_state("R1", 2'b11, 1, 0, 0, 0);
    chk_eq("R1 redirect", 32'(redirect_valid), 0);
    chk_eq("R1 exc", 32'(exc_valid), 0);
  endtask

  task automatic t_machine_ret();
    issue(RET, 1'b1);
    chk_eq("R8 redirect", 32'(redirect_valid), 1);
    chk_eq("R8 exc", 32'(exc_valid), 0);
    chk_eq("R3 target", redirect_pc, 0);
    chk_state("R4/R5 from M", 2'b00, 0, 1, 0, 0);
    @(negedge clk);
    chk_eq("R11 pulse ends", 32'(redirect_valid), 0);
  endtask

  task automatic t_user_illegal();
    issue(RET, 1'b0);
    chk_eq("R6 exc", 32'(exc_valid), 1);
    chk_eq("R6 redirect", 32'(redirect_valid), 0);
    chk_eq("R6 cause", 32'(exc_cause), 2);
    chk_eq("R6 tval", exc_tval, RET);
    chk_state("R6 unchanged", 2'b00, 0, 1, 0, 0);
  endtask

  task automatic t_trap_user();
    trap(32'h8000_1235);
    chk_state("R9 from U", 2'b01, 0, 0, 0, 32'h8000_1234);
  endtask

  task automatic t_non_ret();
    logic [31:0] words [3] = '{32'h3020_0073, 32'h1020_1073, 32'h1020_0033};
    foreach (words[i]) begin
      issue(words[i], 1'b0);
      chk_eq("R2 no redirect", 32'(redirect_valid), 0);
      chk_eq("R2 no exc", 32'(exc_valid), 0);
      chk_state("R2 unchanged", 2'b01, 0, 0, 0, 32'h8000_1234);
    end
  endtask

  task automatic t_sup_tsr();
    issue(RET, 1'b1);
    chk_eq("R7 exc", 32'(exc_valid), 1);
    chk_eq("R7 cause", 32'(exc_cause), 2);
    chk_eq("R7 redirect", 32'(redirect_valid), 0);
    chk_state("R7 unchanged", 2'b01, 0, 0, 0, 32'h8000_1234);
  endtask

  task automatic t_sup_ret();
    issue(RET, 1'b0);
    chk_eq("R3 redirect", 32'(redirect_valid), 1);
    chk_eq("R3 target", redirect_pc, 32'h8000_1234);
    chk_state("R4 to user", 2'b00, 0, 1, 0, 32'h8000_1234);
  endtask

  task automatic t_trap_priority();
    do_reset();
    trap_valid = 1'b1; trap_pc = 32'h44;
    instr_valid = 1'b1; instr = RET; tsr = 1'b0;
    @(posedge clk); @(negedge clk);
    trap_valid = 1'b0; instr_valid = 1'b0;
    chk_eq("R10 no redirect", 32'(redirect_valid), 0);
    chk_eq("R10 no exc", 32'(exc_valid), 0);
    chk_state("R10/R9 from M", 2'b01, 0, 1, 1, 32'h44);
  endtask

  task automatic t_sup_ret_spp();
    issue(RET, 1'b0);
    chk_eq("R3 redirect", 32'(redirect_valid), 1);
    chk_eq("R3 target", redirect_pc, 32'h44);
    chk_state("R4/R5 to S", 2'b01, 1, 1, 0, 32'h44);
  endtask

  initial begin
    t_reset();
    t_machine_ret();
    t_user_illegal();
    t_trap_user();
    t_non_ret();
    t_sup_tsr();
    t_sup_ret();
    t_trap_priority();
    t_sup_ret_spp();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule